// File: doc/BRIEF.md
# Selectable XOR / CRC-8 Checksum Unit

This block keeps a running one-byte integrity value over a stream of bytes, absorbing one byte per clock. A two-bit mode input chooses how each byte is folded in. In XOR mode the byte is XORed into the accumulator. In CRC mode the byte passes, most significant bit first, through a CRC-8 with generator x^8 + x^2 + x + 1. The remaining codes switch the unit off. When off, the accumulator is frozen and the valid flag says that no checksum exists.

A serial register link uses the unit in two ways. On transmit it builds the trailing check byte. On receive it recomputes that byte over the incoming data so the surrounding logic can compare it. A clear pulse starts each transaction from 0x00. All eight bit steps of the CRC are unrolled in combinational logic, so a byte strobe on every cycle is absorbed without stalls.

Top module: `chk8_unit`

## Requirements
- R1: While reset is asserted, and on the first cycle after it is released, `sum_o` reads 0x00.
- R2: A cycle with `clr_i` high makes `sum_o` read 0x00 after the next rising clock edge.
- R3: When `clr_i` and `byte_vld_i` are high in the same cycle, the clear wins and `sum_o` becomes 0x00, whatever the byte and mode.
- R4: In XOR mode (`mode_i` = 2'b01), a strobed byte makes the next `sum_o` equal to the previous `sum_o` XOR the byte.
- R5: In CRC mode (`mode_i` = 2'b10), a strobed byte is absorbed MSB first. For each bit, the accumulator shifts left by one, and the result is XORed with 0x07 when the bit differs from the accumulator's old MSB. Starting from 0x00, the byte 0x01 gives 0x07.
- R6: In off mode (`mode_i` = 2'b00), a byte strobe leaves `sum_o` unchanged and `sum_vld_o` is low.
- R7: Mode code 2'b11 behaves exactly as off mode. `sum_o` is unchanged by strobes and `sum_vld_o` is low.
- R8: `sum_vld_o` is high in the same cycle whenever `mode_i` is 2'b01 or 2'b10.
- R9: With `byte_vld_i` and `clr_i` both low, `sum_o` holds its value.
- R10: Bytes strobed on consecutive cycles are each absorbed, one per clock. A mode change between bytes applies the new mode to the running value without clearing it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| clr_i | input | 1 | Restart the accumulator at 0x00 |
| byte_vld_i | input | 1 | Byte strobe, one byte per cycle |
| byte_i | input | 8 | Byte to absorb |
| mode_i | input | 2 | 00 off, 01 XOR, 10 CRC, 11 off |
| sum_o | output | 8 | Current accumulator value |
| sum_vld_o | output | 1 | A checksum exists in the current mode |

## Verification
The clear pulse and the byte strobe can land in the same cycle. The bench drives both high on purpose, under XOR, CRC and off modes, with non-zero running values and non-zero bytes. The result counts as correct only when the reference model shows 0x00 on the next cycle. A second overlap also gets attention: a mode change on the same cycle as a strobe. The bench judges it by comparing the model against the output on every clock.

// File: rtl/chk8_pkg.sv
package chk8_pkg;

  typedef enum logic [1:0] {
    CK_OFF = 2'b00,
    CK_XOR = 2'b01,
    CK_CRC = 2'b10,
    CK_RSV = 2'b11
  } ck_mode_e;

  function automatic ck_mode_e ck_mode_cast(input logic [1:0] code);
    ck_mode_e m;
    case (code)
      2'b01:   m = CK_XOR;
      2'b10:   m = CK_CRC;
      2'b11:   m = CK_RSV;
      default: m = CK_OFF;
    endcase
    return m;
  endfunction

endpackage

// File: rtl/chk8_mode_dec.sv
module chk8_mode_dec
  import chk8_pkg::*;
(
  input  logic [1:0] mode_i,
  output logic       xor_en_o,
  output logic       crc_en_o,
  output logic       active_o
);

  ck_mode_e mode;

  always_comb begin
    mode     = ck_mode_cast(mode_i);
    xor_en_o = 1'b0;
    crc_en_o = 1'b0;
    unique case (mode)
      CK_XOR:  xor_en_o = 1'b1;
      CK_CRC:  crc_en_o = 1'b1;
      default: ;
    endcase
    active_o = xor_en_o | crc_en_o;
  end

endmodule

// File: rtl/chk8_crc_unroll.sv
module chk8_crc_unroll #(
  parameter int          DW   = 8,
  parameter logic [DW-1:0] POLY = 8'h07
) (
  input  logic [DW-1:0] acc_i,
  input  logic [DW-1:0] data_i,
  output logic [DW-1:0] crc_o
);

  function automatic logic [DW-1:0] crc_bit_step(input logic [DW-1:0] acc,
                                                  input logic          din);
    logic [DW-1:0] sh;
    sh = {acc[DW-2:0], 1'b0};
    return (acc[DW-1] ^ din) ? (sh ^ POLY) : sh;
  endfunction

  logic [DW-1:0] stage [0:DW];

  assign stage[0] = acc_i;

  for (genvar g = 0; g < DW; g++) begin : g_bit
    assign stage[g+1] = crc_bit_step(stage[g], data_i[DW-1-g]);
  end

  assign crc_o = stage[DW];

endmodule

// File: rtl/chk8_accum.sv
module chk8_accum #(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr_i,
  input  logic          load_i,
  input  logic [DW-1:0] next_i,
  output logic [DW-1:0] acc_o
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      acc_o <= '0;
    else if (clr_i)  acc_o <= '0;
    else if (load_i) acc_o <= next_i;
  end

  p_clear_zero_r2: assert property (@(posedge clk) disable iff (!rst_n)
    clr_i |=> (acc_o == '0));

  p_idle_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (!clr_i && !load_i) |=> $stable(acc_o));

endmodule

// File: rtl/chk8_unit.sv
module chk8_unit #(
  parameter int          DW   = 8,
  parameter logic [DW-1:0] POLY = 8'h07
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr_i,
  input  logic          byte_vld_i,
  input  logic [DW-1:0] byte_i,
  input  logic [1:0]    mode_i,
  output logic [DW-1:0] sum_o,
  output logic          sum_vld_o
);

  function automatic logic [DW-1:0] xor_fold(input logic [DW-1:0] acc,
                                              input logic [DW-1:0] din);
    return acc ^ din;
  endfunction

  logic          xor_en, crc_en, mode_active;
  logic          upd_fire, clr_fire;
  logic [DW-1:0] acc, xor_next, crc_next, acc_next;

  chk8_mode_dec u_dec (
    .mode_i  (mode_i),
    .xor_en_o(xor_en),
    .crc_en_o(crc_en),
    .active_o(mode_active)
  );

  chk8_crc_unroll #(.DW(DW), .POLY(POLY)) u_crc (
    .acc_i (acc),
    .data_i(byte_i),
    .crc_o (crc_next)
  );

  assign xor_next = xor_fold(acc, byte_i);
  assign acc_next = crc_en ? crc_next : xor_next;
  assign clr_fire = clr_i;
  assign upd_fire = byte_vld_i & mode_active & ~clr_i;

  chk8_accum #(.DW(DW)) u_acc (
    .clk   (clk),
    .rst_n (rst_n),
    .clr_i (clr_fire),
    .load_i(upd_fire),
    .next_i(acc_next),
    .acc_o (acc)
  );

  assign sum_o     = acc;
  assign sum_vld_o = mode_active;

  p_clr_wins_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_i && byte_vld_i) |=> (sum_o == '0));

  p_xor_fold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (!clr_i && byte_vld_i && mode_i == 2'b01) |=> (sum_o == ($past(sum_o) ^ $past(byte_i))));

  p_crc_zero_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (!clr_i && byte_vld_i && mode_i == 2'b10 && sum_o == '0 && byte_i == '0) |=> (sum_o == '0));

  p_off_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (!clr_i && (mode_i == 2'b00 || mode_i == 2'b11)) |=> $stable(sum_o));

  p_rsv_novld_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_i == 2'b11) |-> !sum_vld_o);

  p_vld_modes_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_i == 2'b01 || mode_i == 2'b10) |-> sum_vld_o);

endmodule

// File: tb/test_chk8_unit.sv
module test_chk8_unit;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       clr_i = 1'b0;
  logic       byte_vld_i = 1'b0;
  logic [7:0] byte_i = 8'h00;
  logic [1:0] mode_i = 2'b00;
  logic [7:0] sum_o;
  logic       sum_vld_o;

  int checks = 0;
  int failures = 0;
  int model = 0;

  always #2.5 clk = ~clk;

  chk8_unit i_chk8_unit (
    .clk       (clk),
    .rst_n     (rst_n),
    .clr_i     (clr_i),
    .byte_vld_i(byte_vld_i),
    .byte_i    (byte_i),
    .mode_i    (mode_i),
    .sum_o     (sum_o),
    .sum_vld_o (sum_vld_o)
  );

  // Reference CRC: polynomial long division, one message bit at a time.
  function automatic int ref_crc(input int acc, input int b);
    int r = acc;
    for (int i = 7; i >= 0; i--) begin
      int top = (r >> 7) & 1;
      int bit_in = (b >> i) & 1;
      r = (r * 2) % 256;
      if (top != bit_in) r = r ^ 7;
    end
    return r;
  endfunction

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // One clock: drive at negedge, check flag, step model, check sum.
  task automatic cyc(input bit c, input bit v, input int b, input int m, input string req);
    clr_i = c; byte_vld_i = v; byte_i = b[7:0]; mode_i = m[1:0];
    #1;
    check((m == 1 || m == 2) ? "R8" : (m == 3 ? "R7" : "R6"),
          int'(sum_vld_o), (m == 1 || m == 2) ? 1 : 0);
    @(posedge clk);
    if (c) model = 0;
    else if (v && m == 1) model = model ^ b;
    else if (v && m == 2) model = ref_crc(model, b);
    @(negedge clk);
    check(req, int'(sum_o), model);
  endtask

  initial begin
    #1000000;
    checks++; failures++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R1", int'(sum_o), 0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1", int'(sum_o), 0);

    // CRC known value: 0x01 from zero gives 0x07
    cyc(0, 1, 8'h01, 2, "R5");
    check("R5", int'(sum_o), 8'h07);
    cyc(0, 1, 8'hA5, 2, "R5");
    cyc(0, 1, 8'h80, 2, "R5");
    cyc(0, 1, 8'hFF, 2, "R5");
    // clear
    cyc(1, 0, 0, 2, "R2");
    // XOR stream
    cyc(0, 1, 8'h3C, 1, "R4");
    cyc(0, 1, 8'hC3, 1, "R4");
    cyc(0, 1, 8'h5A, 1, "R4");
    // idle holds
    cyc(0, 0, 8'hFF, 1, "R9");
    cyc(0, 0, 8'h12, 2, "R9");
    // off and reserved ignore strobes
    cyc(0, 1, 8'h77, 0, "R6");
    cyc(0, 1, 8'h99, 3, "R7");
    cyc(0, 1, 8'h01, 3, "R7");
    // clear vs strobe in each mode
    cyc(0, 1, 8'h42, 2, "R5");
    cyc(1, 1, 8'hE1, 2, "R3");
    cyc(0, 1, 8'h42, 1, "R4");
    cyc(1, 1, 8'h18, 1, "R3");
    cyc(0, 1, 8'h6B, 2, "R5");
    cyc(1, 1, 8'h6B, 0, "R3");
    // back-to-back with mode switching, no clear
    cyc(0, 1, 8'h11, 1, "R10");
    cyc(0, 1, 8'h22, 2, "R10");
    cyc(0, 1, 8'h33, 1, "R10");
    cyc(0, 1, 8'h44, 2, "R10");
    // mixed stream
    for (int k = 0; k < 400; k++) begin
      int r = $urandom;
      cyc(((r >> 12) % 23) == 0, ((r >> 8) % 5) != 0, r & 255, (r >> 16) % 4, "R10");
    end
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule